// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block fronts an on-chip scratchpad of 16 KB built from 16 banks of 32-bit words. One issue carries a vector of per-lane word addresses. Each lane has its own valid bit, and the issue as a whole is either a read or a write. The block sorts the lanes by bank. In each cycle it drives at most one distinct row into every bank. It replays the issue over as many cycles as the worst bank needs, and then returns the read words in lane order with a one-cycle completion pulse. Lanes that name the same word share one access. A merged read hands the word to every lane in the group. A merged write keeps one lane's data.

A second access mode models a single-ported constant store. In this mode only one distinct address is served per cycle, whatever banks the lanes fall in. An issue whose lanes all name one address finishes in a single cycle, and the mode never writes. While an issue is being replayed the block holds its busy output high, and any new issue offered during that time is dropped.

Top module: `spad_bank_arbiter`

## Requirements
- R1: A word address splits into bank = address bits [3:0] and row = address bits [11:4]. A word written through the block is returned unchanged by a later read of the same address.
- R2: An issue whose valid lanes fall in pairwise distinct banks completes in one pass: done pulses on the first rising edge after the edge that accepted the issue.
- R3: When valid lanes hit the same bank at different rows, the issue is replayed. The number of passes (edges from acceptance to done) equals the largest count of distinct addresses found in any one bank.
- R4: Valid lanes that name the same word cost a single access in that pass, and each of them receives that word.
- R5: Invalid lanes take no part in conflict counting, and their 32-bit field of rd_data reads zero. An issue with no valid lanes completes in one pass.
- R6: Lane i's read word appears in rd_data bits [32*i+31 : 32*i], whatever order the addresses take.
- R7: busy is high from the edge that accepts an issue until the edge that raises done. An issue_valid seen while busy is high is ignored and writes nothing.
- R8: With mode_const = 1, each pass serves exactly one distinct address across all lanes. The pass count is the number of distinct valid addresses, so a single shared address finishes in one pass.
- R9: With mode_const = 1, the issue_write input is ignored: nothing is written and read data is returned.
- R10: When several valid lanes write the same word in one issue, the data of the highest-numbered such lane is stored.
- R11: After reset, busy and done are low and rd_data is all zero.
- R12: done is a one-cycle pulse. rd_data holds its value until the next issue is accepted, and is all zero for a write issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Offers an issue; accepted on an edge where busy is low |
| issue_write | input | 1 | 1 = write issue, 0 = read issue |
| mode_const | input | 1 | 1 = single-address-per-pass constant mode |
| lane_valid | input | 16 | Per-lane request valid |
| lane_addr | input | 192 | Lane i word address in bits [12*i+11 : 12*i] |
| lane_wdata | input | 512 | Lane i write data in bits [32*i+31 : 32*i] |
| busy | output | 1 | Issue in replay; new issues are dropped |
| done | output | 1 | One-cycle pulse after the last pass |
| rd_data | output | 512 | Per-lane read words in lane order |

## Verification
Broadcast merging and conflict replay can fall in the same pass, so the bench mixes them in one issue. One group of lanes shares a single word, while other lanes hit the same bank at other rows. Such an issue is correct only if it finishes in as many passes as the bank has distinct addresses, not as many as it has lanes, and every lane of the merged group gets the same word. A second collision puts a new issue on the input in the middle of a long replay, and a later readback of the targeted words confirms the offer left the memory untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic {
        MODE_BANKED = 1'b0,
        MODE_CONST  = 1'b1
    } access_mode_e;

    typedef struct packed {
        logic         active;
        logic         is_write;
        access_mode_e mode;
    } replay_state_t;

    function automatic int unsigned count_lanes(input logic [63:0] mask, input int unsigned n);
        int unsigned c;
        c = 0;
        for (int unsigned i = 0; i < n; i++) begin
            if (mask[i]) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
    parameter int LANES   = 16,
    parameter int BANKS   = 16,
    parameter int ROWS    = 256,
    parameter int DW      = 32,
    parameter int BANK_ID = 0,
    localparam int BB     = $clog2(BANKS),
    localparam int AW     = $clog2(BANKS * ROWS),
    localparam int RW     = AW - BB
) (
    input  logic [LANES-1:0]    cand,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES*DW-1:0] wdata_flat,
    output logic [LANES-1:0]    serve,
    output logic                hit,
    output logic [RW-1:0]       row,
    output logic [DW-1:0]       wdata
);
    localparam logic [BB-1:0] MY_BANK = BB'(BANK_ID);

    always_comb begin
        logic [AW-1:0] a;
        serve = '0;
        hit   = 1'b0;
        row   = '0;
        wdata = '0;
        a     = '0;
        // leader: lowest candidate lane in this bank
        for (int i = 0; i < LANES; i++) begin
            a = addr_flat[i*AW +: AW];
            if (cand[i] && a[BB-1:0] == MY_BANK && !hit) begin
                hit = 1'b1;
                row = a[AW-1:BB];
            end
        end
        // followers sharing the leader's row merge; last one wins the write
        for (int i = 0; i < LANES; i++) begin
            a = addr_flat[i*AW +: AW];
            if (cand[i] && hit && a[BB-1:0] == MY_BANK && a[AW-1:BB] == row) begin
                serve[i] = 1'b1;
                wdata    = wdata_flat[i*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/sp_bank_mem.sv
module sp_bank_mem #(
    parameter int ROWS = 256,
    parameter int DW   = 32,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (we) store[row] <= wdata;
    end

    assign rdata = store[row];
endmodule

// File: rtl/sp_replay_ctrl.sv
module sp_replay_ctrl
    import sp_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 12,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic                issue_write,
    input  logic                mode_const,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    input  logic [LANES-1:0]    serve,
    input  logic [LANES*DW-1:0] lane_rd,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rd_data,
    output logic [LANES-1:0]    pending,
    output logic [LANES*AW-1:0] req_addr,
    output logic [LANES*DW-1:0] req_wdata,
    output replay_state_t       st
);
    logic [LANES-1:0] remain;
    assign remain = pending & ~serve;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{active: 1'b0, is_write: 1'b0, mode: MODE_BANKED};
            pending   <= '0;
            done      <= 1'b0;
            rd_data   <= '0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            done <= 1'b0;
            if (!st.active) begin
                if (issue_valid) begin
                    st.active   <= 1'b1;
                    st.is_write <= issue_write & ~mode_const;
                    st.mode     <= mode_const ? MODE_CONST : MODE_BANKED;
                    pending     <= lane_valid;
                    req_addr    <= lane_addr;
                    req_wdata   <= lane_wdata;
                    rd_data     <= '0;
                end
            end else begin
                pending <= remain;
                for (int i = 0; i < LANES; i++) begin
                    if (serve[i] && !st.is_write) rd_data[i*DW +: DW] <= lane_rd[i*DW +: DW];
                end
                if (remain == '0) begin
                    st.active <= 1'b0;
                    done      <= 1'b1;
                end
            end
        end
    end

    assign busy = st.active;

    assert_hold_request_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && issue_valid) |=> ($stable(req_addr) && $stable(req_wdata)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_pending_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/spad_bank_arbiter.sv
module spad_bank_arbiter
    import sp_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int ROWS  = 256,
    parameter int DW    = 32,
    localparam int BB   = $clog2(BANKS),
    localparam int AW   = $clog2(BANKS * ROWS),
    localparam int RW   = AW - BB
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic                issue_write,
    input  logic                mode_const,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] rd_data
);
    logic [LANES-1:0]    pending;
    logic [LANES*AW-1:0] req_addr;
    logic [LANES*DW-1:0] req_wdata;
    replay_state_t       st;
    logic [LANES-1:0]    serve;
    logic [LANES*DW-1:0] lane_rd;
    logic [LANES-1:0]    const_serve;
    logic [LANES-1:0]    cand;

    logic [LANES-1:0] bank_serve [BANKS];
    logic [DW-1:0]    bank_rd    [BANKS];
    logic [BANKS-1:0] bank_hit;
    logic [BANKS-1:0] bank_we;

    sp_replay_ctrl #(.LANES(LANES), .AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_write (issue_write),
        .mode_const  (mode_const),
        .lane_valid  (lane_valid),
        .lane_addr   (lane_addr),
        .lane_wdata  (lane_wdata),
        .serve       (serve),
        .lane_rd     (lane_rd),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .pending     (pending),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .st          (st)
    );

    // constant mode: lowest pending lane picks the one address of this pass
    always_comb begin
        logic          found;
        logic [AW-1:0] lead;
        found       = 1'b0;
        lead        = '0;
        const_serve = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && !found) begin
                found = 1'b1;
                lead  = req_addr[i*AW +: AW];
            end
        end
        for (int i = 0; i < LANES; i++) begin
            const_serve[i] = pending[i] && found && (req_addr[i*AW +: AW] == lead);
        end
    end

    assign cand = (st.mode == MODE_CONST) ? const_serve : pending;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [RW-1:0] row;
        logic [DW-1:0] wd;

        sp_bank_pick #(
            .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DW(DW), .BANK_ID(b)
        ) u_pick (
            .cand       (cand),
            .addr_flat  (req_addr),
            .wdata_flat (req_wdata),
            .serve      (bank_serve[b]),
            .hit        (bank_hit[b]),
            .row        (row),
            .wdata      (wd)
        );

        assign bank_we[b] = st.active && st.is_write && (st.mode == MODE_BANKED) && bank_hit[b];

        sp_bank_mem #(.ROWS(ROWS), .DW(DW)) u_mem (
            .clk   (clk),
            .we    (bank_we[b]),
            .row   (row),
            .wdata (wd),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        serve = '0;
        for (int b = 0; b < BANKS; b++) serve = serve | bank_serve[b];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BB-1:0] bsel;
        assign bsel = req_addr[i*AW +: BB];
        assign lane_rd[i*DW +: DW] = bank_rd[bsel];
    end

    assert_progress_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && pending != '0) |-> (serve != '0));

    assert_const_one_bank_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && st.mode == MODE_CONST && pending != '0) |-> $onehot(bank_hit));

    assert_const_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (st.mode == MODE_CONST) |-> (bank_we == '0));

    assert_serve_in_pending_R5: assert property (@(posedge clk) disable iff (rst)
        (serve & ~pending) == '0);
endmodule

// File: tb/sim_spad_bank_arbiter.sv
module sim_spad_bank_arbiter;
    localparam int L  = 16;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_valid = 1'b0, issue_write = 1'b0, mode_const = 1'b0;
    logic [L-1:0]    lane_valid = '0;
    logic [L*AW-1:0] lane_addr  = '0;
    logic [L*DW-1:0] lane_wdata = '0;
    logic busy, done;
    logic [L*DW-1:0] rd_data;

    spad_bank_arbiter u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_write(issue_write),
        .mode_const(mode_const), .lane_valid(lane_valid), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .busy(busy), .done(done), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        int           lat;
        logic [L*DW-1:0] rd;
        string        tag;
    } exp_t;

    exp_t q[$];
    logic [31:0] ref_mem [4096];
    int checks = 0, failures = 0;
    int cyc = 0, accept_cyc = 0;
    bit finished = 0;

    logic [L-1:0]  t_val;
    logic [AW-1:0] t_addr [L];
    logic [DW-1:0] t_wd   [L];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_passes(input bit cst);
        int best = 1;
        for (int b = 0; b < 16; b++) begin
            int n = 0;
            for (int i = 0; i < L; i++) begin
                bit first = 1;
                if (!t_val[i]) continue;
                if (!cst && t_addr[i][3:0] != 4'(b)) continue;
                for (int j = 0; j < i; j++)
                    if (t_val[j] && t_addr[j] == t_addr[i]) first = 0;
                if (first) n++;
            end
            if (n > best) best = n;
            if (cst) break;
        end
        return best;
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // driver: computes expectation, pushes it, then offers the issue
    task automatic do_issue(input string tag, input bit wr, input bit cst);
        exp_t e;
        wait_idle();
        e.tag = tag;
        e.lat = exp_passes(cst);
        e.rd  = '0;
        for (int i = 0; i < L; i++) begin
            if (t_val[i] && (!wr || cst)) e.rd[i*DW +: DW] = ref_mem[t_addr[i]];
        end
        if (wr && !cst) begin
            for (int i = 0; i < L; i++) if (t_val[i]) ref_mem[t_addr[i]] = t_wd[i];
        end
        q.push_back(e);
        issue_valid = 1'b1;
        issue_write = wr;
        mode_const  = cst;
        lane_valid  = t_val;
        for (int i = 0; i < L; i++) begin
            lane_addr[i*AW +: AW]  = t_addr[i];
            lane_wdata[i*DW +: DW] = t_wd[i];
        end
        @(negedge clk);
        accept_cyc = cyc;
        check({tag, " R7 busy after accept"}, {{(L*DW-1){1'b0}}, busy}, {{(L*DW-1){1'b0}}, 1'b1});
        issue_valid = 1'b0;
    endtask

    // monitor: pops and compares on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R12 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cyc - accept_cyc != e.lat) begin
                    failures++;
                    $display("FAIL %s latency actual=%0d expected=%0d", e.tag, cyc - accept_cyc, e.lat);
                end
                check({e.tag, " data"}, rd_data, e.rd);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 busy/done", {{(L*DW-2){1'b0}}, busy, done}, '0);
        check("R11 rd_data", rd_data, '0);

        // R1 R2: fill words 0..255, one row per issue, all banks distinct
        for (int k = 0; k < 16; k++) begin
            t_val = '1;
            for (int i = 0; i < L; i++) begin
                t_addr[i] = AW'(k*16 + i);
                t_wd[i]   = 32'hA500_0000 + 32'(k*16 + i) * 32'd977;
            end
            do_issue("R1 R2 R12 fill write", 1, 0);
        end

        // R2 R6: row 0 in lane order, then row 2 reversed
        t_val = '1;
        for (int i = 0; i < L; i++) t_addr[i] = AW'(i);
        do_issue("R1 R2 R6 read row0", 0, 0);
        for (int i = 0; i < L; i++) t_addr[i] = AW'(32 + 15 - i);
        do_issue("R6 reversed read", 0, 0);

        // R4: every lane the same word
        for (int i = 0; i < L; i++) t_addr[i] = AW'(37);
        do_issue("R4 all merged", 0, 0);

        // R3: all lanes bank 3, distinct rows -> 16 passes; stray issue mid-replay (R7)
        for (int i = 0; i < L; i++) t_addr[i] = AW'(i*16 + 3);
        do_issue("R3 full conflict", 0, 0);
        issue_valid = 1'b1; issue_write = 1'b1; mode_const = 1'b0; lane_valid = '1;
        for (int i = 0; i < L; i++) begin
            lane_addr[i*AW +: AW]  = AW'(200 + i);
            lane_wdata[i*DW +: DW] = 32'hDEAD_0000 + 32'(i);
        end
        @(negedge clk);
        @(negedge clk);
        issue_valid = 1'b0;

        // R3: stride 2 -> two rows per even bank
        for (int i = 0; i < L; i++) t_addr[i] = AW'(2*i);
        do_issue("R3 stride2", 0, 0);

        // R3 R4: merge and conflict in one bank: 3 distinct words in bank 5
        for (int i = 0; i < L; i++) t_addr[i] = (i < 8) ? AW'(5) : (i < 12) ? AW'(21) : AW'(37);
        do_issue("R3 R4 merge+conflict", 0, 0);

        // R5: invalid lanes hold conflicting addresses
        t_val = 16'h00FF;
        for (int i = 0; i < L; i++) t_addr[i] = (i < 8) ? AW'(64 + i) : AW'(i*16);
        do_issue("R5 invalid lanes", 0, 0);
        t_val = '0;
        do_issue("R5 empty issue", 0, 0);

        // R10: all lanes write word 100, lane 15 must win
        t_val = '1;
        for (int i = 0; i < L; i++) begin
            t_addr[i] = AW'(100);
            t_wd[i]   = 32'h1000_0000 + 32'(i);
        end
        do_issue("R10 write merge", 1, 0);
        do_issue("R10 readback", 0, 0);

        // R8: constant mode
        for (int i = 0; i < L; i++) t_addr[i] = AW'(50);
        do_issue("R8 const shared", 0, 1);
        for (int i = 0; i < L; i++) t_addr[i] = AW'(i + 16);
        do_issue("R8 const distinct banks", 0, 1);
        for (int i = 0; i < L; i++) t_addr[i] = AW'((i % 4) * 16 + 7);
        do_issue("R8 const four words", 0, 1);

        // R9: const with write flag reads and stores nothing
        for (int i = 0; i < L; i++) begin
            t_addr[i] = AW'(60);
            t_wd[i]   = 32'hBAD0_0000 + 32'(i);
        end
        do_issue("R9 const write ignored", 1, 1);
        do_issue("R9 readback", 0, 0);

        // R7: stray issue during replay must not have written
        for (int i = 0; i < L; i++) t_addr[i] = AW'(200 + i);
        do_issue("R7 stray readback", 0, 0);

        wait_idle();
        @(negedge clk);
        check("R12 queue drained", L*DW'(q.size()), '0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule